// File: doc/BRIEF.md
# Two-Pin GPIO Port with Timer Override

This block is a small memory-mapped general-purpose I/O port with two pins. Software reaches it over a byte-wide register bus. Through that bus it sets a per-pin output latch and a per-pin direction bit. The block drives a per-pin output value and output enable toward the pads. It samples the pad inputs through a two-flop synchronizer, and the synchronized level goes both to the read path and to an external timer.

An external timer can take over any pin for input capture or output compare by raising that pin's timer-enable. While the timer-enable is high, the timer's output value and output enable drive the pad, and the direction bit has no effect on the driver. The direction bit still picks what a read of the latch register returns: the latch when the bit is 1, and the synchronized pin when the bit is 0.

Software can preload the latch while a pin is still an input. It then sets the direction bit, so the first driven value is already correct and the pin does not glitch.

Top module: `gpio_timer_port`

## Requirements
- R1: The latch register is at byte address 0x03 and the direction register at 0x07. Bits 1:0 of each are implemented, bit i belonging to pin i. A write takes effect at the rising clock edge where `bus_wr` is high.
- R2: Bits 7:2 of both registers read as 0, and writes to them are ignored. A read of any address other than 0x03 or 0x07 returns 0x00.
- R3: Reset clears both direction bits, so with no timer override every `pad_oe` bit is 0 during and after reset.
- R4: Reset leaves the latch register unchanged. A value written before a reset pulse reads back after it.
- R5: With the pin's timer-enable low and direction 1, `pad_oe` is 1 and `pad_out` equals the latch bit. With direction 0, `pad_oe` is 0.
- R6: With the pin's timer-enable high, `pad_oe` follows `tmr_oe` and `pad_out` follows `tmr_out`, whatever the direction bit holds.
- R7: A read of address 0x03 returns, per bit, the latch when the direction bit is 1 and the synchronized pin level when it is 0. This holds also while the timer owns the pin.
- R8: A change on `pad_in` appears on `tmr_pin`, and in latch-register reads of input pins, after exactly two rising clock edges. The synchronizer resets to 0.
- R9: The latch register is writable whatever the direction bits hold. A preloaded value is driven on `pad_out` in the very cycle the direction bit turns to 1.
- R10: `bus_rdata` is 0x00 whenever `bus_rd` is low, and it is combinational from address and state while `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 2 | Raw pad input levels |
| pad_out | output | 2 | Pad output values |
| pad_oe | output | 2 | Pad output-driver enables |
| tmr_en | input | 2 | Per-pin timer ownership |
| tmr_out | input | 2 | Timer output value per pin |
| tmr_oe | input | 2 | Timer output enable per pin |
| tmr_pin | output | 2 | Synchronized pin level to the timer |

## Verification
Register writes show up one edge after the strobe: the direction bit changes `pad_oe` and `pad_out` in the same cycle it changes. Read data and the timer override path have no register, so they are due in the cycle their inputs change. A pad change is due on `tmr_pin` and in reads after the second rising edge. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It compares two time units after each rising edge, and its directed checks sample one time unit after a falling edge, so every expected value is taken in the cycle it is due.

// File: rtl/gpio_timer_pkg.sv
package gpio_timer_pkg;
  typedef logic [7:0] byte_t;

  // Per-bit read-back choice: latch where the direction bit is set, pin elsewhere
  function automatic byte_t pick_readback(input byte_t latch, input byte_t dir, input byte_t pin);
    return (latch & dir) | (pin & ~dir);
  endfunction

  // Driver choice for one pin: timer wins, else the direction bit
  function automatic logic pick_oe(input logic own, input logic t_oe, input logic dir);
    return own ? t_oe : dir;
  endfunction

  function automatic logic pick_out(input logic own, input logic t_out, input logic latch);
    return own ? t_out : latch;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_timer_pkg::*;
#(
  parameter int          NPINS    = 2,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  DAT_ADDR = 8'h03,
  parameter logic [7:0]  DIR_ADDR = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  byte_t             wdata,
  input  logic [NPINS-1:0]  pin_sync,
  output logic [NPINS-1:0]  dat_q,
  output logic [NPINS-1:0]  dir_q,
  output logic              wr_dat,
  output logic              wr_dir,
  output byte_t             rdata
);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_ADDR);

  logic             hit_dat, hit_dir;
  logic [7:NPINS]   unused_wdata_hi;

  assign hit_dat         = (addr == A_DAT);
  assign hit_dir         = (addr == A_DIR);
  assign wr_dat          = wr && hit_dat;
  assign wr_dir          = wr && hit_dir;
  assign unused_wdata_hi = wdata[7:NPINS];

  // Output latch: deliberately not reset
  always_ff @(posedge clk) begin
    if (wr_dat) dat_q <= wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata[NPINS-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_dat)      rdata = pick_readback(byte_t'(dat_q), byte_t'(dir_q), byte_t'(pin_sync));
      else if (hit_dir) rdata = byte_t'(dir_q);
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_timer_pkg::*;
#(
  parameter int NPINS = 2
) (
  input  logic [NPINS-1:0] dat_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] tmr_en,
  input  logic [NPINS-1:0] tmr_out,
  input  logic [NPINS-1:0] tmr_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic owned;
    assign owned      = tmr_en[i];
    assign pad_oe[i]  = pick_oe(owned, tmr_oe[i], dir_q[i]);
    assign pad_out[i] = pick_out(owned, tmr_out[i], dat_q[i]);
  end
endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port #(
  parameter int         NPINS       = 2,
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] DAT_ADDR    = 8'h03,
  parameter logic [7:0] DIR_ADDR    = 8'h07,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  tmr_en,
  input  logic [NPINS-1:0]  tmr_out,
  input  logic [NPINS-1:0]  tmr_oe,
  output logic [NPINS-1:0]  tmr_pin
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] dat_q;
  logic [NPINS-1:0] dir_q;
  logic             wr_dat;
  logic             wr_dir;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DAT_ADDR(DAT_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .pin_sync(pin_sync), .dat_q(dat_q), .dir_q(dir_q),
    .wr_dat(wr_dat), .wr_dir(wr_dir), .rdata(bus_rdata)
  );

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .dat_q(dat_q), .dir_q(dir_q), .tmr_en(tmr_en), .tmr_out(tmr_out),
    .tmr_oe(tmr_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign tmr_pin = pin_sync;
endmodule

// File: rtl/gpio_timer_chk.sv
module gpio_timer_chk #(
  parameter int NPINS  = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [NPINS-1:0]  wr_bits,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  tmr_en,
  input logic [NPINS-1:0]  tmr_oe,
  input logic [NPINS-1:0]  tmr_pin,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  dat_q,
  input logic              wr_dat,
  input logic              wr_dir
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wr_bits));

  a_r1_dat_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> dat_q == $past(wr_bits));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:NPINS] == '0);

  a_r2_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(3) && bus_addr != ADDR_W'(7)) |-> bus_rdata == 8'h00);

  a_r3_dir_cleared: assert property (@(posedge clk)
    $rose(rst_n) |-> dir_q == '0);

  a_r5_input_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~tmr_en & ~dir_q) == '0);

  a_r6_timer_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en & (pad_oe ^ tmr_oe)) == '0);

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> tmr_pin == $past(pad_in, 2));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);
endmodule

bind gpio_timer_port gpio_timer_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .wr_bits(bus_wdata[NPINS-1:0]), .pad_in(pad_in),
  .pad_oe(pad_oe), .tmr_en(tmr_en), .tmr_oe(tmr_oe), .tmr_pin(tmr_pin),
  .dir_q(dir_q), .dat_q(dat_q), .wr_dat(wr_dat), .wr_dir(wr_dir)
);

// File: tb/sim_gpio_timer_port.sv
`timescale 1ns/1ps
module sim_gpio_timer_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr, bus_rd;
  logic [1:0] pad_in, pad_out, pad_oe, tmr_en, tmr_out, tmr_oe, tmr_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_timer_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .tmr_en(tmr_en), .tmr_out(tmr_out), .tmr_oe(tmr_oe), .tmr_pin(tmr_pin)
  );

  // Reference model state
  bit [1:0] m_dat, m_dir, m_s1, m_s2, m_known;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      if (bus_wr && bus_addr == 8'h03) begin m_dat <= bus_wdata[1:0]; m_known <= 2'b11; end
      if (bus_wr && bus_addr == 8'h07) m_dir <= bus_wdata[1:0];
      m_s1 <= pad_in;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, two time units after each rising edge
  always @(posedge clk) begin
    #2;
    for (int i = 0; i < 2; i++) begin
      logic eo;
      eo = tmr_en[i] ? tmr_oe[i] : m_dir[i];
      chk(tmr_en[i] ? "R6 pad_oe" : "R5 pad_oe", {7'b0, pad_oe[i]}, {7'b0, eo});
      if (eo && tmr_en[i]) chk("R6 pad_out", {7'b0, pad_out[i]}, {7'b0, tmr_out[i]});
      else if (eo && m_known[i]) chk("R5 pad_out", {7'b0, pad_out[i]}, {7'b0, m_dat[i]});
      chk("R8 tmr_pin", {7'b0, tmr_pin[i]}, {7'b0, m_s2[i]});
    end
    begin
      logic [7:0] er;
      bit ok;
      er = 0; ok = 1;
      if (bus_rd && bus_addr == 8'h07) er = {6'b0, m_dir};
      else if (bus_rd && bus_addr == 8'h03)
        for (int i = 0; i < 2; i++) begin
          if (m_dir[i]) begin er[i] = m_dat[i]; if (!m_known[i]) ok = 0; end
          else er[i] = m_s2[i];
        end
      if (ok) chk("R7/R2/R10 rdata", bus_rdata, er);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
    pad_in = 2'b10; tmr_en = 0; tmr_out = 0; tmr_oe = 0;
    repeat (3) @(negedge clk);
    chk("R3 pad_oe in reset", {6'b0, pad_oe}, 8'h00);
    rst_n = 1;
    bus_read(8'h07, 8'h00, "R3 dir after reset");
    chk("R3 pad_oe after reset", {6'b0, pad_oe}, 8'h00);
    // Preload latch while inputs; read returns synced pins
    bus_write(8'h03, 8'hFF);
    bus_read(8'h03, 8'h02, "R9/R7 read of input pins");
    bus_write(8'h07, 8'hFD);
    bus_read(8'h07, 8'h01, "R1/R2 dir readback upper ignored");
    bus_write(8'h07, 8'h03);
    bus_read(8'h03, 8'h03, "R7 latch readback");
    chk("R5 pad_oe", {6'b0, pad_oe}, 8'h03);
    chk("R5 pad_out", {6'b0, pad_out}, 8'h03);
    bus_read(8'h05, 8'h00, "R2 unmapped address");
    bus_read(8'h83, 8'h00, "R2 alias address");
    @(negedge clk); bus_rd = 0; bus_addr = 8'h03;
    #1 chk("R10 idle read", bus_rdata, 8'h00);
    // Timer override on pin 0
    @(negedge clk); tmr_en = 2'b01; tmr_oe = 2'b00; tmr_out = 2'b00;
    #1 chk("R6 timer disables driver", {6'b0, pad_oe}, 8'h02);
    bus_write(8'h07, 8'h00);
    @(negedge clk); tmr_oe = 2'b01; tmr_out = 2'b01;
    #1 chk("R6 timer drives despite dir 0", {6'b0, pad_oe}, 8'h01);
    chk("R6 timer value", {7'b0, pad_out[0]}, 8'h01);
    pad_in = 2'b00;
    repeat (3) @(negedge clk);
    bus_read(8'h03, 8'h00, "R7 pin read while timer owns");
    bus_write(8'h03, 8'h01);
    bus_write(8'h07, 8'h01);
    pad_in = 2'b00;
    bus_read(8'h03, 8'h01, "R7 latch read while timer owns");
    bus_rd = 0; tmr_en = 0; tmr_oe = 0; tmr_out = 0;
    // Synchronizer latency
    bus_write(8'h07, 8'h00);
    @(negedge clk); pad_in = 2'b11;
    @(negedge clk); chk("R8 one edge: old", {6'b0, tmr_pin}, 8'h00);
    @(negedge clk); chk("R8 two edges: new", {6'b0, tmr_pin}, 8'h03);
    // Latch survives reset
    bus_write(8'h03, 8'h02);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    bus_read(8'h07, 8'h00, "R3 dir cleared by reset");
    bus_rd = 0;
    bus_write(8'h07, 8'h03);
    bus_read(8'h03, 8'h02, "R4 latch kept through reset");
    bus_rd = 0;
    // Preload then enable: driven value correct in first cycle
    bus_write(8'h07, 8'h00);
    bus_write(8'h03, 8'h01);
    @(negedge clk); bus_addr = 8'h07; bus_wdata = 8'h01; bus_wr = 1;
    @(posedge clk); #1;
    chk("R9 first driven value", {7'b0, pad_out[0]}, 8'h01);
    chk("R9 first driven enable", {6'b0, pad_oe}, 8'h01);
    @(negedge clk); bus_wr = 0;
    // Random traffic compared by the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      case ($urandom_range(0, 3))
        0: bus_addr = 8'h03;
        1: bus_addr = 8'h07;
        default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = 8'($urandom); bus_wr = ($urandom_range(0, 3) == 0);
      bus_rd = $urandom_range(0, 1) == 1;
      pad_in = 2'($urandom); tmr_en = 2'($urandom);
      tmr_oe = 2'($urandom); tmr_out = 2'($urandom);
    end
    @(negedge clk); bus_wr = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule